// File: doc/BRIEF.md
# Keyed Watchdog Timer

This block is a watchdog timer on a simple synchronous register bus. Its counter counts upward from a programmable start value. It advances on a slow timebase pulse `tick_i`, and an optional prescaler can divide that pulse by a power of two. Software keeps the system alive by writing a fresh value to the kick register, which restarts the counter from the start value. If the counter runs past all ones, the block raises a one-cycle reset request and stops.

The watchdog is started and stopped only through two-word key sequences written to the key register. Every write to control, start value, kick or key is posted. The write takes effect a fixed number of cycles after the bus accepts it. While it is in flight, a per-register busy flag is high, and further writes to that register are dropped. Control and start-value writes that land while the watchdog runs are discarded, so the timeout cannot be altered once the timer is armed.

Register word addresses on `bus_addr_i`: 0 control, 1 start value, 2 counter (read only), 3 kick, 4 key, 5 busy flags (read only), 6 identifier (read only). Reads are combinational on `bus_rdata_o`.

Top module: `wdog_keyed_top`

## Requirements
- R1: After reset, the control, start value, counter, kick and busy registers read 0, and the identifier register reads 0x31 in bits 7:0.
- R2: Writing 0xBBBB and then 0x4444 to the key register starts the watchdog. Once started, the counter advances by one per counted tick. While stopped, ticks leave the counter unchanged.
- R3: Writing 0xAAAA and then 0x5555 to the key register stops the watchdog, and ticks no longer move the counter.
- R4: A key write that does not complete a pair is handled in one of two ways. A wrong second word discards the partial sequence. A lone second word with no first word before it is ignored. In both cases the run state is unchanged.
- R5: The busy register has bit 0 for control, bit 2 for start value, bit 3 for kick and bit 4 for key. A flag is high for exactly 4 cycles after its write is accepted, and the write takes effect at the end of those 4 cycles. A write to a register whose flag is high is dropped.
- R6: Control and start-value writes that take effect while the watchdog runs are discarded.
- R7: A kick write whose value differs from the last kick value reloads the counter from the start value. A kick write that repeats the last value has no effect.
- R8: Control bit 5 enables the prescaler, and bits 4:2 hold the ratio field r. When the prescaler is enabled, the counter advances once per 2^r ticks, counting from the last reload. When it is disabled, the counter advances on every tick.
- R9: A counted tick at the all-ones value wraps the counter to 0, pulses `rst_req_o` for exactly one cycle, and stops the watchdog until it is rearmed.
- R10: A kick reload that takes effect in the same cycle as a counted tick at all ones wins. The counter takes the start value, no reset request is raised, and the watchdog keeps running.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| bus_req_i | input | 1 | Bus access strobe |
| bus_we_i | input | 1 | Write enable for the access |
| bus_addr_i | input | 3 | Register word address |
| bus_wdata_i | input | 32 | Write data |
| bus_rdata_o | output | 32 | Read data for the addressed register |
| tick_i | input | 1 | Slow timebase pulse, one cycle wide |
| rst_req_o | output | 1 | One-cycle reset request on overflow |

## Verification
The overflow of the counter and the posted commit of a kick reload can fall on the same clock edge. The bench provokes this with the counter held at all ones and the watchdog armed. It issues a kick with a new value and raises `tick_i` exactly in the cycle of that kick's commit edge, four cycles after acceptance. The result is judged by `rst_req_o` staying low, the counter reading the start value, and a later tick still producing an overflow, which shows the watchdog kept running.

// File: rtl/wdog_pkg.sv
package wdog_pkg;
  localparam int ADDR_W  = 3;
  localparam int DATA_W  = 32;
  localparam int RATIO_W = 3;

  typedef enum logic [ADDR_W-1:0] {
    A_CTRL  = 3'd0,
    A_LOAD  = 3'd1,
    A_COUNT = 3'd2,
    A_TRIG  = 3'd3,
    A_KEY   = 3'd4,
    A_PEND  = 3'd5,
    A_REV   = 3'd6
  } reg_addr_e;

  localparam logic [DATA_W-1:0] KEY_ARM_A = 32'h0000_BBBB;
  localparam logic [DATA_W-1:0] KEY_ARM_B = 32'h0000_4444;
  localparam logic [DATA_W-1:0] KEY_OFF_A = 32'h0000_AAAA;
  localparam logic [DATA_W-1:0] KEY_OFF_B = 32'h0000_5555;

  // busy flag bit positions, decoded by software
  localparam int PB_CTRL = 0;
  localparam int PB_LOAD = 2;
  localparam int PB_TRIG = 3;
  localparam int PB_KEY  = 4;

  localparam int CB_PRE_EN   = 5;
  localparam int CB_RATIO_LO = 2;

  typedef struct packed {
    logic               pre_en;
    logic [RATIO_W-1:0] ratio;
  } ctrl_t;
endpackage

// File: rtl/wdog_post_slot.sv
module wdog_post_slot #(
  parameter int DW  = 32,
  parameter int LAT = 4
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          wr_i,
  input  logic [DW-1:0] wdata_i,
  output logic          pend_o,
  output logic          commit_o,
  output logic [DW-1:0] data_o
);
  localparam int CW = $clog2(LAT + 1);

  logic [CW-1:0] cnt_q;
  logic [DW-1:0] data_q;
  logic          accept;

  assign accept   = wr_i && (cnt_q == '0);
  assign pend_o   = (cnt_q != '0);
  assign commit_o = (cnt_q == CW'(1));
  assign data_o   = data_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q  <= '0;
      data_q <= '0;
    end else if (accept) begin
      cnt_q  <= CW'(LAT);
      data_q <= wdata_i;
    end else if (cnt_q != '0) begin
      cnt_q <= cnt_q - CW'(1);
    end
  end

  AST_PEND_SET: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_i && !pend_o) |=> pend_o); // R5
  AST_BUSY_DROP: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_i && pend_o) |=> $stable(data_o)); // R5
endmodule

// File: rtl/wdog_key_seq.sv
module wdog_key_seq
  import wdog_pkg::*;
(
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              commit_i,
  input  logic [DATA_W-1:0] data_i,
  input  logic              ovf_i,
  output logic              run_o
);
  typedef enum logic [1:0] {K_IDLE, K_ARM1, K_OFF1} key_st_e;

  key_st_e st_q;
  logic    run_q;

  assign run_o = run_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      st_q  <= K_IDLE;
      run_q <= 1'b0;
    end else if (ovf_i) begin
      st_q  <= K_IDLE;
      run_q <= 1'b0;
    end else if (commit_i) begin
      unique case (st_q)
        K_IDLE: begin
          if (data_i == KEY_ARM_A)      st_q <= K_ARM1;
          else if (data_i == KEY_OFF_A) st_q <= K_OFF1;
        end
        K_ARM1: begin
          st_q <= K_IDLE;
          if (data_i == KEY_ARM_B) run_q <= 1'b1;
        end
        K_OFF1: begin
          st_q <= K_IDLE;
          if (data_i == KEY_OFF_B) run_q <= 1'b0;
        end
        default: st_q <= K_IDLE;
      endcase
    end
  end

  AST_ARM_KEYED: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(run_o) |-> $past(commit_i && data_i == KEY_ARM_B)); // R2
  AST_DISARM_KEYED: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(run_o) |-> $past(ovf_i || (commit_i && data_i == KEY_OFF_B))); // R3
endmodule

// File: rtl/wdog_count_core.sv
module wdog_count_core #(
  parameter int CNT_W = 32,
  parameter int PRE_W = 3
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             run_i,
  input  logic             tick_i,
  input  logic             pre_en_i,
  input  logic [PRE_W-1:0] ratio_i,
  input  logic             reload_i,
  input  logic [CNT_W-1:0] load_i,
  output logic [CNT_W-1:0] cnt_o,
  output logic             ovf_now_o,
  output logic             rst_req_o
);
  localparam int PS_W = (1 << PRE_W) - 1;

  logic [CNT_W-1:0] cnt_q;
  logic [PS_W-1:0]  ps_q, ps_lim;
  logic             cnt_tick, adv, req_q;

  always_comb ps_lim = PS_W'((32'd1 << ratio_i) - 32'd1);

  assign cnt_tick  = run_i && tick_i;
  assign adv       = cnt_tick && (!pre_en_i || ps_q == ps_lim);
  assign ovf_now_o = adv && (&cnt_q) && !reload_i;
  assign cnt_o     = cnt_q;
  assign rst_req_o = req_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q <= '0;
      ps_q  <= '0;
      req_q <= 1'b0;
    end else begin
      req_q <= ovf_now_o;
      if (reload_i) begin
        cnt_q <= load_i;
        ps_q  <= '0;
      end else begin
        if (adv) cnt_q <= cnt_q + CNT_W'(1);
        if (cnt_tick && pre_en_i) ps_q <= (ps_q == ps_lim) ? '0 : ps_q + PS_W'(1);
      end
    end
  end

  AST_REQ_PULSE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rst_req_o |=> !rst_req_o); // R9
  AST_FROZEN: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!run_i && !reload_i) |=> $stable(cnt_o)); // R3
  AST_RELOAD_WINS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    reload_i |=> (!rst_req_o && cnt_o == $past(load_i))); // R10
endmodule

// File: rtl/wdog_keyed_top.sv
module wdog_keyed_top
  import wdog_pkg::*;
#(
  parameter int          CNT_W    = 32,
  parameter int          POST_LAT = 4,
  parameter logic [7:0]  REV_ID   = 8'h31
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              bus_req_i,
  input  logic              bus_we_i,
  input  logic [ADDR_W-1:0] bus_addr_i,
  input  logic [DATA_W-1:0] bus_wdata_i,
  output logic [DATA_W-1:0] bus_rdata_o,
  input  logic              tick_i,
  output logic              rst_req_o
);
  localparam int NSLOT = 4;
  localparam int S_CTRL = 0, S_LOAD = 1, S_TRIG = 2, S_KEY = 3;
  localparam logic [ADDR_W-1:0] SLOT_ADDR [NSLOT] = '{A_CTRL, A_LOAD, A_TRIG, A_KEY};

  logic [NSLOT-1:0]  s_pend, s_commit;
  logic [DATA_W-1:0] s_data [NSLOT];

  for (genvar g = 0; g < NSLOT; g++) begin : g_slot
    logic wr;
    assign wr = bus_req_i && bus_we_i && (bus_addr_i == SLOT_ADDR[g]);
    wdog_post_slot #(.DW(DATA_W), .LAT(POST_LAT)) i_slot (
      .clk_i    (clk_i),
      .rst_ni   (rst_ni),
      .wr_i     (wr),
      .wdata_i  (bus_wdata_i),
      .pend_o   (s_pend[g]),
      .commit_o (s_commit[g]),
      .data_o   (s_data[g])
    );
  end

  logic              run, ovf_now, reload;
  ctrl_t             ctrl_q;
  logic [CNT_W-1:0]  load_q, cnt;
  logic [DATA_W-1:0] trig_q;

  assign reload = s_commit[S_TRIG] && (s_data[S_TRIG] != trig_q);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      ctrl_q <= '0;
      load_q <= '0;
      trig_q <= '0;
    end else begin
      if (s_commit[S_CTRL] && !run) begin
        ctrl_q.pre_en <= s_data[S_CTRL][CB_PRE_EN];
        ctrl_q.ratio  <= s_data[S_CTRL][CB_RATIO_LO +: RATIO_W];
      end
      if (s_commit[S_LOAD] && !run) load_q <= s_data[S_LOAD][CNT_W-1:0];
      if (s_commit[S_TRIG]) trig_q <= s_data[S_TRIG];
    end
  end

  wdog_key_seq i_key (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .commit_i (s_commit[S_KEY]),
    .data_i   (s_data[S_KEY]),
    .ovf_i    (ovf_now),
    .run_o    (run)
  );

  wdog_count_core #(.CNT_W(CNT_W), .PRE_W(RATIO_W)) i_core (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .run_i     (run),
    .tick_i    (tick_i),
    .pre_en_i  (ctrl_q.pre_en),
    .ratio_i   (ctrl_q.ratio),
    .reload_i  (reload),
    .load_i    (load_q),
    .cnt_o     (cnt),
    .ovf_now_o (ovf_now),
    .rst_req_o (rst_req_o)
  );

  always_comb begin
    bus_rdata_o = '0;
    unique case (bus_addr_i)
      A_CTRL:  begin
        bus_rdata_o[CB_PRE_EN] = ctrl_q.pre_en;
        bus_rdata_o[CB_RATIO_LO +: RATIO_W] = ctrl_q.ratio;
      end
      A_LOAD:  bus_rdata_o = DATA_W'(load_q);
      A_COUNT: bus_rdata_o = DATA_W'(cnt);
      A_TRIG:  bus_rdata_o = trig_q;
      A_PEND:  begin
        bus_rdata_o[PB_CTRL] = s_pend[S_CTRL];
        bus_rdata_o[PB_LOAD] = s_pend[S_LOAD];
        bus_rdata_o[PB_TRIG] = s_pend[S_TRIG];
        bus_rdata_o[PB_KEY]  = s_pend[S_KEY];
      end
      A_REV:   bus_rdata_o[7:0] = REV_ID;
      default: bus_rdata_o = '0;
    endcase
  end

  AST_CFG_LOCK: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (run && s_commit[S_CTRL]) |=> $stable(ctrl_q)); // R6
  AST_LOAD_LOCK: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (run && s_commit[S_LOAD]) |=> $stable(load_q)); // R6
endmodule

// File: tb/test_wdog_keyed_top.sv
module test_wdog_keyed_top;
  logic        clk = 1'b0, rst_ni = 1'b0, req = 1'b0, we = 1'b0, tick = 1'b0;
  logic [2:0]  addr = '0;
  logic [31:0] wdata = '0, rdata;
  logic        rst_req;
  int          checks = 0, errors = 0, cyc = 0;
  logic [31:0] tv = 0, base, v;

  always #5 clk = ~clk;

  wdog_keyed_top i_wdog_keyed_top (
    .clk_i(clk), .rst_ni(rst_ni), .bus_req_i(req), .bus_we_i(we),
    .bus_addr_i(addr), .bus_wdata_i(wdata), .bus_rdata_o(rdata),
    .tick_i(tick), .rst_req_o(rst_req)
  );

  always @(posedge clk) begin
    cyc++;
    if (cyc > 50000) begin
      errors++;
      $display("FAIL watchdog expired act=%0d exp=<50000", cyc);
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  task automatic chk(string r, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s act=%h exp=%h", r, act, exp);
    end
  endtask

  task automatic rd(logic [2:0] a, output logic [31:0] d);
    addr = a; #1 d = rdata;
  endtask

  task automatic wr(logic [2:0] a, logic [31:0] d);
    @(negedge clk); req = 1; we = 1; addr = a; wdata = d;
    @(negedge clk); req = 0; we = 0;
  endtask

  task automatic wr_done(logic [2:0] a, logic [31:0] d);
    wr(a, d); repeat (4) @(negedge clk);
  endtask

  task automatic ticks(int n);
    repeat (n) begin @(negedge clk); tick = 1; @(negedge clk); tick = 0; end
  endtask

  task automatic arm();    wr_done(4, 32'hBBBB); wr_done(4, 32'h4444); endtask
  task automatic disarm(); wr_done(4, 32'hAAAA); wr_done(4, 32'h5555); endtask
  task automatic kick();   tv++; wr_done(3, tv); endtask
  task automatic cnt_is(string r, logic [31:0] e); logic [31:0] x; rd(2, x); chk(r, x, e); endtask

  initial begin
    logic [2:0]  pa [4] = '{3'd0, 3'd1, 3'd3, 3'd4};
    int          pb [4] = '{0, 2, 3, 4};
    logic [31:0] pd [4] = '{32'h0, 32'hFFFF_FF00, 32'h0, 32'h1234};
    repeat (3) @(negedge clk);
    rst_ni = 1;
    @(negedge clk);

    // R1 reset state
    rd(0, v); chk("R1 ctrl", v, 0);
    rd(1, v); chk("R1 load", v, 0);
    rd(2, v); chk("R1 count", v, 0);
    rd(3, v); chk("R1 kick", v, 0);
    rd(5, v); chk("R1 busy", v, 0);
    rd(6, v); chk("R1 rev", {24'd0, v[7:0]}, 32'h31);
    chk("R1 rst_req", {31'd0, rst_req}, 0);

    // R5 busy flag position and duration per register
    for (int k = 0; k < 4; k++) begin
      wr(pa[k], pd[k]);
      for (int i = 0; i < 4; i++) begin
        rd(5, v); chk("R5 busy high", v, 32'd1 << pb[k]);
        @(negedge clk);
      end
      rd(5, v); chk("R5 busy low", v, 0);
    end
    rd(1, v); chk("R5 load committed", v, 32'hFFFF_FF00);

    // R5 write during busy dropped
    wr(0, 32'h24); wr(0, 32'h0C); repeat (4) @(negedge clk);
    rd(0, v); chk("R5 busy drop", v, 32'h24);
    wr_done(0, 32'h0);

    // R7 kick reload, repeated value ignored
    kick(); cnt_is("R7 reload", 32'hFFFF_FF00);
    ticks(3); cnt_is("R2 stopped frozen", 32'hFFFF_FF00);
    arm();
    base = 32'hFFFF_FF00;
    for (int k = 1; k <= 5; k++) begin
      ticks(k); base += k; cnt_is("R2 count per tick", base);
    end
    wr_done(3, tv); cnt_is("R7 same kick ignored", base);
    kick(); cnt_is("R7 new kick reload", 32'hFFFF_FF00);

    // R6 config locked while running
    wr_done(0, 32'h3C); rd(0, v); chk("R6 ctrl locked", v, 0);
    wr_done(1, 32'h10); rd(1, v); chk("R6 load locked", v, 32'hFFFF_FF00);
    ticks(2); kick(); cnt_is("R6 reload old load", 32'hFFFF_FF00);

    // R4 broken sequences
    wr_done(4, 32'hAAAA); wr_done(4, 32'h1234);
    ticks(2); cnt_is("R4 broken disarm", 32'hFFFF_FF02);
    wr_done(4, 32'h5555);
    ticks(1); cnt_is("R4 lone second word", 32'hFFFF_FF03);
    disarm();
    ticks(3); cnt_is("R3 disarmed", 32'hFFFF_FF03);
    wr_done(4, 32'hBBBB); wr_done(4, 32'h5555);
    ticks(2); cnt_is("R4 broken arm", 32'hFFFF_FF03);

    // R8 prescaler sweep
    for (int r = 0; r < 4; r++) begin
      int n;
      n = 4 * (1 << r) - 1;
      wr_done(0, 32'h20 | (r << 2));
      rd(0, v); chk("R8 ctrl field", v, 32'h20 | (r << 2));
      kick(); arm(); ticks(n);
      cnt_is("R8 prescaled", 32'hFFFF_FF00 + (n >> r));
      disarm();
    end
    wr_done(0, 32'h0C); kick(); arm(); ticks(5);
    cnt_is("R8 prescaler off", 32'hFFFF_FF05);
    disarm();

    // R9 overflow
    wr_done(0, 0); wr_done(1, 32'hFFFF_FFFD); kick(); arm();
    ticks(2); cnt_is("R9 at max", 32'hFFFF_FFFF);
    chk("R9 no req yet", {31'd0, rst_req}, 0);
    @(negedge clk); tick = 1; @(negedge clk); tick = 0;
    chk("R9 req pulse", {31'd0, rst_req}, 1);
    cnt_is("R9 wrap", 0);
    @(negedge clk); chk("R9 req one cycle", {31'd0, rst_req}, 0);
    ticks(3); cnt_is("R9 stopped", 0);
    arm(); ticks(2); cnt_is("R9 rearm", 2);
    disarm();

    // R10 reload vs overflow same edge
    wr_done(1, 32'hFFFF_FFFF); kick(); arm();
    cnt_is("R10 setup", 32'hFFFF_FFFF);
    tv++; wr(3, tv); repeat (3) @(negedge clk);
    tick = 1; @(negedge clk); tick = 0;
    chk("R10 no req", {31'd0, rst_req}, 0);
    cnt_is("R10 reload wins", 32'hFFFF_FFFF);
    @(negedge clk); chk("R10 still no req", {31'd0, rst_req}, 0);
    @(negedge clk); tick = 1; @(negedge clk); tick = 0;
    chk("R10 still running", {31'd0, rst_req}, 1);

    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule